// File: doc/BRIEF.md
# Checksummed Command Packet to Register Bus Decoder

This block reads a byte stream from a host link and turns each fixed-size command packet into one access on a simple register bus. A packet begins with a sync value, carries a 15-bit register address whose top byte also holds a write flag, then one data byte, and ends with a checksum byte. The checksum protects the four bytes before it. When a packet checks out, the block performs the single read or write it describes.

Every completed access is reported back to the host as a response packet with the same five-byte shape. The data byte holds the value written or the value read, and the checksum is recomputed over the response. The response stream marks its final byte, so a downstream merger can switch between sources only on packet edges. While an access or its response is still in flight, the byte input is stalled.

Top module: `csr_cmd_decoder`

## Requirements
- R1: While hunting for a packet start, every input byte other than the sync value 0x55 is consumed and discarded, with no bus access and no response.
- R2: A packet is five bytes in this order: sync 0x55, address high, address low, data, checksum. Bit 7 of the address high byte set means write and clear means read. The register address is {high[6:0], low}, 15 bits wide.
- R3: The checksum is the sum of the four preceding bytes modulo 256. A packet whose checksum differs is dropped with no bus access and no response, and the parser goes back to hunting for sync.
- R4: A valid write packet drives csr_we high for exactly one cycle, the cycle after the checksum byte is accepted, with the packet's address on csr_addr and its data byte on csr_wdata.
- R5: A valid read packet presents its address on csr_addr in the cycle after the checksum byte is accepted, and the value on csr_rdata at the end of that cycle becomes the read result. csr_we stays low.
- R6: Every valid packet produces a five-byte response: 0x55, the address high byte including the write flag, the address low byte, the data byte (written value for writes, read value for reads), then the modulo-256 sum of those four bytes.
- R7: out_last is high on the fifth response byte and low on the other four.
- R8: in_ready is low from the cycle after the checksum byte is accepted until the fifth response byte is taken. While out_ready is low, out_valid stays high and out_data holds its value.
- R9: After reset, in_ready is high, out_valid is low and csr_we is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte from host |
| in_ready | output | 1 | Block can take an input byte |
| csr_addr | output | 15 | Register address |
| csr_we | output | 1 | Register write strobe |
| csr_wdata | output | 8 | Register write data |
| csr_rdata | input | 8 | Register read data |
| out_valid | output | 1 | Response byte present |
| out_data | output | 8 | Response byte |
| out_last | output | 1 | Final byte of a response |
| out_ready | input | 1 | Consumer takes the response byte |

## Verification
Writes and reads are tried at addresses that set and clear the top address bits. This separates the write flag from the address and shows whether the read path returns stored data rather than the echoed data byte. A packet with a checksum off by one is followed at once by a good packet, which tests both that the bad packet is dropped and that the parser goes back to hunting. Bytes other than the sync value sent ahead of a packet test the discarding during the hunt. A response held back by a low out_ready tests that the output holds its value and that the input stays stalled.

// File: rtl/csr_cmd_pkg.sv
package csr_cmd_pkg;
  localparam int BYTE_W  = 8;
  localparam int PKT_LEN = 5;
  localparam int IDX_W   = $clog2(PKT_LEN);
  localparam int ADDR_W  = 2 * BYTE_W - 1;

  function automatic logic [BYTE_W-1:0] frame_sum(
    input logic [BYTE_W-1:0] a, input logic [BYTE_W-1:0] b,
    input logic [BYTE_W-1:0] c, input logic [BYTE_W-1:0] d);
    return a + b + c + d;
  endfunction

  function automatic logic [BYTE_W-1:0] rsp_byte(
    input logic [IDX_W-1:0] idx, input logic [BYTE_W-1:0] sync,
    input logic [BYTE_W-1:0] hi, input logic [BYTE_W-1:0] lo,
    input logic [BYTE_W-1:0] dat);
    case (idx)
      3'd0:    return sync;
      3'd1:    return hi;
      3'd2:    return lo;
      3'd3:    return dat;
      default: return frame_sum(sync, hi, lo, dat);
    endcase
  endfunction
endpackage

// File: rtl/csr_pkt_parser.sv
module csr_pkt_parser
  import csr_cmd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SYNC = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              cmd_fire,
  output logic [BYTE_W-1:0] hdr_hi,
  output logic [BYTE_W-1:0] hdr_lo,
  output logic [BYTE_W-1:0] hdr_data
);
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] hi_q, lo_q, dat_q;
  logic              sum_ok;

  assign sum_ok   = (byte_in == frame_sum(SYNC, hi_q, lo_q, dat_q));
  assign hdr_hi   = hi_q;
  assign hdr_lo   = lo_q;
  assign hdr_data = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      dat_q    <= '0;
      cmd_fire <= 1'b0;
    end else begin
      cmd_fire <= 1'b0;
      if (take) begin
        case (idx)
          3'd0: if (byte_in == SYNC) idx <= 3'd1;
          3'd1: begin hi_q  <= byte_in; idx <= 3'd2; end
          3'd2: begin lo_q  <= byte_in; idx <= 3'd3; end
          3'd3: begin dat_q <= byte_in; idx <= 3'd4; end
          default: begin
            idx      <= '0;
            cmd_fire <= sum_ok;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/csr_bus_stage.sv
module csr_bus_stage
  import csr_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic [BYTE_W-1:0] hdr_hi,
  input  logic [BYTE_W-1:0] hdr_lo,
  input  logic [BYTE_W-1:0] hdr_data,
  input  logic [BYTE_W-1:0] csr_rdata,
  output logic [ADDR_W-1:0] csr_addr,
  output logic              csr_we,
  output logic [BYTE_W-1:0] csr_wdata,
  output logic              txn_vld,
  output logic [BYTE_W-1:0] txn_data
);
  logic is_write;

  assign is_write  = hdr_hi[BYTE_W-1];
  assign csr_addr  = {hdr_hi[BYTE_W-2:0], hdr_lo};
  assign csr_wdata = hdr_data;
  assign csr_we    = cmd_fire & is_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txn_vld  <= 1'b0;
      txn_data <= '0;
    end else begin
      txn_vld <= cmd_fire;
      if (cmd_fire) txn_data <= is_write ? hdr_data : csr_rdata;
    end
  end
endmodule

// File: rtl/csr_rsp_sender.sv
module csr_rsp_sender
  import csr_cmd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SYNC = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_vld,
  input  logic [BYTE_W-1:0] hdr_hi,
  input  logic [BYTE_W-1:0] hdr_lo,
  input  logic [BYTE_W-1:0] txn_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              rsp_done
);
  logic              active;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] hi_q, lo_q, dat_q;

  assign out_valid = active;
  assign out_last  = active && (idx == IDX_W'(PKT_LEN - 1));
  assign out_data  = rsp_byte(idx, SYNC, hi_q, lo_q, dat_q);
  assign rsp_done  = out_last && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      dat_q  <= '0;
    end else if (txn_vld) begin
      active <= 1'b1;
      idx    <= '0;
      hi_q   <= hdr_hi;
      lo_q   <= hdr_lo;
      dat_q  <= txn_data;
    end else if (active && out_ready) begin
      if (rsp_done) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/csr_cmd_decoder.sv
module csr_cmd_decoder
  import csr_cmd_pkg::*;
#(
  parameter logic [7:0] SYNC = 8'h55
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic [14:0] csr_addr,
  output logic        csr_we,
  output logic [7:0]  csr_wdata,
  input  logic [7:0]  csr_rdata,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  input  logic        out_ready
);
  logic              take;
  logic              cmd_fire;
  logic              txn_vld;
  logic              rsp_done;
  logic [BYTE_W-1:0] hdr_hi, hdr_lo, hdr_data, txn_data;

  assign in_ready = !(cmd_fire || txn_vld || out_valid);
  assign take     = in_valid && in_ready;

  csr_pkt_parser #(.SYNC(SYNC)) u_parser (
    .clk(clk), .rst_n(rst_n), .take(take), .byte_in(in_data),
    .cmd_fire(cmd_fire), .hdr_hi(hdr_hi), .hdr_lo(hdr_lo), .hdr_data(hdr_data)
  );

  csr_bus_stage u_bus (
    .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .hdr_hi(hdr_hi),
    .hdr_lo(hdr_lo), .hdr_data(hdr_data), .csr_rdata(csr_rdata),
    .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .txn_vld(txn_vld), .txn_data(txn_data)
  );

  csr_rsp_sender #(.SYNC(SYNC)) u_rsp (
    .clk(clk), .rst_n(rst_n), .txn_vld(txn_vld), .hdr_hi(hdr_hi),
    .hdr_lo(hdr_lo), .txn_data(txn_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .rsp_done(rsp_done)
  );
endmodule

// File: rtl/csr_cmd_decoder_chk.sv
module csr_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       csr_we,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       cmd_fire,
  input logic       txn_vld,
  input logic       rsp_done
);
  // R4
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> !csr_we);
  // R4
  fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !cmd_fire);
  // R8
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  // R6
  txn_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_vld |=> out_valid);
  // R7
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !out_valid);
endmodule

bind csr_cmd_decoder csr_cmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .csr_we(csr_we),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .cmd_fire(cmd_fire), .txn_vld(txn_vld),
  .rsp_done(rsp_done)
);

// File: tb/csr_cmd_decoder_tb.sv
module csr_cmd_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic [14:0] csr_addr;
  logic        csr_we;
  logic [7:0]  csr_wdata;
  logic [7:0]  csr_rdata;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_last;
  logic        out_ready = 1'b1;

  int total = 0;
  int bad = 0;
  int we_cnt = 0;
  int rsp_cnt = 0;
  bit finished = 1'b0;
  logic [7:0] mem [0:255];
  logic [7:0] rbyte [0:255];
  logic       rlast [0:255];

  always #4 clk = ~clk;

  csr_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
  );

  assign csr_rdata = mem[csr_addr[7:0]];

  always @(posedge clk) begin
    if (rst_n && csr_we) begin
      mem[csr_addr[7:0]] <= csr_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (rst_n && out_valid && out_ready && rsp_cnt < 256) begin
      rbyte[rsp_cnt] <= out_data;
      rlast[rsp_cnt] <= out_last;
      rsp_cnt <= rsp_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sum4(input logic [7:0] a, b, c, d);
    int s = int'(a) + int'(b) + int'(c) + int'(d);
    return s[7:0];
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_rsp(input int target);
    for (int i = 0; i < 50 && rsp_cnt < target; i++) @(negedge clk);
  endtask

  task automatic check_rsp(input int base, input logic [7:0] hi, lo, d, input string tag);
    logic [7:0] exp [0:4];
    exp[0] = 8'h55; exp[1] = hi; exp[2] = lo; exp[3] = d;
    exp[4] = sum4(8'h55, hi, lo, d);
    check(rsp_cnt == base + 5, {tag, " R6 response length"}, rsp_cnt - base, 5);
    for (int k = 0; k < 5; k++) begin
      check(rbyte[base+k] == exp[k], {tag, " R6 response byte"}, rbyte[base+k], exp[k]);
      check(rlast[base+k] == (k == 4), {tag, " R7 last flag"}, rlast[base+k], k == 4);
    end
  endtask

  task automatic do_write(input logic [14:0] addr, input logic [7:0] d, input string tag);
    logic [7:0] hi, lo;
    int base;
    hi = {1'b1, addr[14:8]};
    lo = addr[7:0];
    base = rsp_cnt;
    send_byte(8'h55); send_byte(hi); send_byte(lo); send_byte(d);
    send_byte(sum4(8'h55, hi, lo, d));
    check(csr_we == 1'b1, {tag, " R4 write strobe"}, csr_we, 1);
    check(csr_addr == addr, {tag, " R2 address"}, csr_addr, addr);
    check(csr_wdata == d, {tag, " R4 write data"}, csr_wdata, d);
    check(in_ready == 1'b0, {tag, " R8 input stalled"}, in_ready, 0);
    @(negedge clk);
    check(csr_we == 1'b0, {tag, " R4 single cycle"}, csr_we, 0);
    wait_rsp(base + 5);
    check_rsp(base, hi, lo, d, tag);
  endtask

  task automatic do_read(input logic [14:0] addr, input logic [7:0] junk, input string tag);
    logic [7:0] hi, lo, expd;
    int base, wb;
    hi = {1'b0, addr[14:8]};
    lo = addr[7:0];
    expd = mem[addr[7:0]];
    base = rsp_cnt;
    wb = we_cnt;
    send_byte(8'h55); send_byte(hi); send_byte(lo); send_byte(junk);
    send_byte(sum4(8'h55, hi, lo, junk));
    check(csr_we == 1'b0, {tag, " R5 no write on read"}, csr_we, 0);
    check(csr_addr == addr, {tag, " R5 read address"}, csr_addr, addr);
    wait_rsp(base + 5);
    check(we_cnt == wb, {tag, " R5 no write count"}, we_cnt, wb);
    check_rsp(base, hi, lo, expd, tag);
  endtask

  task automatic t_reset;
    check(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    check(csr_we == 1'b0, "R9 csr_we", csr_we, 0);
  endtask

  task automatic t_doc_example;
    int base = rsp_cnt;
    int wb = we_cnt;
    mem[3] = 8'hEE;
    send_byte(8'h55); send_byte(8'h80); send_byte(8'h03); send_byte(8'h00);
    send_byte(8'hD8);
    check(csr_we == 1'b1 && csr_addr == 15'h0003, "R2 example write", csr_addr, 3);
    wait_rsp(base + 5);
    check(we_cnt == wb + 1 && mem[3] == 8'h00, "R3 example stored", mem[3], 0);
    check_rsp(base, 8'h80, 8'h03, 8'h00, "example");
  endtask

  task automatic t_garbage;
    int base = rsp_cnt;
    int wb = we_cnt;
    send_byte(8'h00); send_byte(8'hAA); send_byte(8'h12); send_byte(8'hD8);
    repeat (4) @(negedge clk);
    check(rsp_cnt == base, "R1 no response for junk", rsp_cnt, base);
    check(we_cnt == wb, "R1 no write for junk", we_cnt, wb);
    do_write(15'h0042, 8'h9C, "R1 after junk");
  endtask

  task automatic t_bad_sum;
    int base = rsp_cnt;
    int wb = we_cnt;
    logic [7:0] s = sum4(8'h55, 8'h80, 8'h10, 8'h77) + 8'h01;
    send_byte(8'h55); send_byte(8'h80); send_byte(8'h10); send_byte(8'h77);
    send_byte(s);
    check(csr_we == 1'b0, "R3 no strobe on bad sum", csr_we, 0);
    check(in_ready == 1'b1, "R3 input open after drop", in_ready, 1);
    repeat (6) @(negedge clk);
    check(rsp_cnt == base, "R3 no response", rsp_cnt, base);
    check(we_cnt == wb, "R3 no write", we_cnt, wb);
    do_write(15'h0010, 8'h31, "R3 recovery");
  endtask

  task automatic t_backpressure;
    int base;
    out_ready = 1'b0;
    base = rsp_cnt;
    send_byte(8'h55); send_byte(8'hC1); send_byte(8'h20); send_byte(8'h5A);
    send_byte(sum4(8'h55, 8'hC1, 8'h20, 8'h5A));
    repeat (5) @(negedge clk);
    check(out_valid == 1'b1, "R8 valid held", out_valid, 1);
    check(out_data == 8'h55, "R8 first byte held", out_data, 8'h55);
    check(in_ready == 1'b0, "R8 stalled during response", in_ready, 0);
    check(rsp_cnt == base, "R8 nothing taken", rsp_cnt, base);
    for (int k = 0; k < 10; k++) begin
      out_ready = k[0];
      @(negedge clk);
    end
    out_ready = 1'b1;
    wait_rsp(base + 5);
    @(negedge clk);
    check(in_ready == 1'b1, "R8 input reopens", in_ready, 1);
    check_rsp(base, 8'hC1, 8'h20, 8'h5A, "R8 throttled");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'hA5);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_doc_example();
    do_write(15'h7FAB, 8'h3C, "R2 high address write");
    do_read(15'h7FAB, 8'h00, "R5 readback");
    do_read(15'h0001, 8'hFF, "R5 untouched read");
    t_garbage();
    t_bad_sum();
    t_backpressure();
    do_read(15'h4120, 8'h11, "R5 after throttle");
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule